// File: doc/BRIEF.md
# Eight-bit arithmetic and logic unit with status flags

This block is the data path of a small eight-bit processor core. It forms a result from one or two byte operands and an operation code in the same cycle. It also keeps an eight-bit status register, which records what the last operations produced. The result is purely combinational. The status register changes only on a clock edge on which the execute strobe is high.

Each operation writes its own set of status flags and leaves every other flag as it was. Two further operations set or clear any single status bit, chosen by a three-bit index. Add-with-carry, subtract-with-carry and the two rotates take their carry input from the stored carry flag. A chain of byte operations can therefore add, subtract or compare multi-byte values.

The status register bits, from bit 7 down to bit 0, are: interrupt enable (I), user bit (T), half carry (H), sign (S), overflow (V), negative (N), zero (Z) and carry (C).

Top module: `alu8_flags`

## Requirements
- R1: After reset, the status output is 0x00. On any clock edge with `en_i` low, the status output does not change, whatever the operation.
- R2: Status bit positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0. No operation except the flag set (17) and flag clear (18) changes I or T.
- R3: ADD (op 0) gives a+b, and ADC (op 1) gives a+b+C. Both write H, S, V, N, Z and C:
  - C is the carry out of bit 7.
  - H is the carry out of bit 3.
  - V is signed overflow.
  - N is result bit 7.
  - Z is set when the result is zero.
- R4: SUB (op 2) gives a-b, and SBC (op 3) gives a-b-C. C and H are the borrows out of bit 7 and bit 3, and V is signed overflow. SUB sets Z when the result is zero. SBC clears Z when the result is non-zero and otherwise leaves Z unchanged.
- R5: AND (4), OR (5) and XOR (6) give the bitwise result. They write Z and N, clear V and leave C and H unchanged.
- R6: INC (9) gives a+1 and DEC (10) gives a-1, modulo 256. Each writes Z, N and S. V is set only when INC yields 0x80 or DEC yields 0x7F. C and H are unchanged.
- R7: COM (7) gives 0xFF-a and sets C to 1, clears V, and writes Z and N. NEG (8) gives 0x00-a:
  - C is set when a is non-zero.
  - H is set when the low nibble of a is non-zero.
  - V is set when a is 0x80.
  - Z and N are written.
- R8: Shifts write C, Z, N and V, with V = N xor C, and leave H unchanged:
  - LSL (11) shifts left and puts 0 into bit 0. C takes old bit 7.
  - LSR (12) shifts right and puts 0 into bit 7. C takes old bit 0.
  - ASR (13) shifts right and keeps bit 7. C takes old bit 0.
- R9: Rotates write C, Z, N and V, with V = N xor C, and leave H unchanged:
  - ROL (14) moves the old C into bit 0 and the old bit 7 into C.
  - ROR (15) moves the old C into bit 7 and the old bit 0 into C.
- R10: SWAP (16) exchanges the two nibbles of a and changes no flag.
- R11: Flag set (17) writes 1, and flag clear (18) writes 0, to the status bit indexed by `bit_i`. The result output equals a.
- R12: For every operation that writes N or V, the stored S equals N xor V.
- R13: Codes 19 to 31 give result a and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Execute strobe; the status register updates on this edge |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (destination value) |
| b_i | input | 8 | Second operand |
| bit_i | input | 3 | Status bit index for flag set and clear |
| result_o | output | 8 | Combinational result |
| sreg_o | output | 8 | Status register |

## Verification
The bench drives every first operand against a spread of second operands chosen to hit the half-carry and sign boundaries. It compares each result and each status value against a model built from plain integer arithmetic.

Some faults it looks for, and what each would do:
- H taken from the wrong bit would misreport the nibble carries at 0x0F and 0x10.
- V with a wrong sign rule would disagree at the 0x7F/0x80 edges of INC, DEC and NEG.
- A zero test on SBC that ignored the old Z would break multi-byte compares.
- A rotate fed from the new carry instead of the old one would corrupt bit 0 or bit 7.

It also confirms that SWAP, unused codes and idle edges leave the flags untouched.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ALU_W  = 8;
    localparam int HALF_W = ALU_W / 2;
    localparam int OP_W   = 5;
    localparam int IDX_W  = 3;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_S = 4;
    localparam int FLG_H = 5;
    localparam int FLG_T = 6;
    localparam int FLG_I = 7;

    localparam logic [ALU_W-1:0] WR_ARITH = 8'b0011_1111;
    localparam logic [ALU_W-1:0] WR_ZNVS  = 8'b0001_1110;
    localparam logic [ALU_W-1:0] WR_SHIFT = 8'b0001_1111;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_COM  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_LSL  = 5'd11,
        OP_LSR  = 5'd12,
        OP_ASR  = 5'd13,
        OP_ROL  = 5'd14,
        OP_ROR  = 5'd15,
        OP_SWAP = 5'd16,
        OP_BSET = 5'd17,
        OP_BCLR = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic [ALU_W-1:0] res;
        logic [ALU_W-1:0] val;
        logic [ALU_W-1:0] wr;
    } unit_out_t;

    typedef struct packed {
        logic [ALU_W-1:0] sreg;
    } alu_state_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e          op_i,
    input  logic [ALU_W-1:0] a_i,
    input  logic [ALU_W-1:0] b_i,
    input  logic             c_i,
    input  logic             z_i,
    output unit_out_t        out_o
);

    logic [ALU_W-1:0]  lhs_d;
    logic [ALU_W-1:0]  rhs_d;
    logic [ALU_W-1:0]  rhs_eff_d;
    logic              cin_d;
    logic              cin_eff_d;
    logic              sub_d;
    logic [ALU_W-1:0]  wr_d;
    logic [ALU_W:0]    sum_d;
    logic [HALF_W:0]   low_d;
    logic              n_d;
    logic              v_d;
    logic              z_d;

    always_comb begin
        lhs_d = a_i;
        rhs_d = b_i;
        cin_d = 1'b0;
        sub_d = 1'b0;
        wr_d  = '0;
        case (op_i)
            OP_ADD: wr_d = WR_ARITH;
            OP_ADC: begin
                cin_d = c_i;
                wr_d  = WR_ARITH;
            end
            OP_SUB: begin
                sub_d = 1'b1;
                wr_d  = WR_ARITH;
            end
            OP_SBC: begin
                sub_d = 1'b1;
                cin_d = c_i;
                wr_d  = WR_ARITH;
            end
            OP_INC: begin
                rhs_d = ALU_W'(1);
                wr_d  = WR_ZNVS;
            end
            OP_DEC: begin
                rhs_d = ALU_W'(1);
                sub_d = 1'b1;
                wr_d  = WR_ZNVS;
            end
            OP_NEG: begin
                lhs_d = '0;
                rhs_d = a_i;
                sub_d = 1'b1;
                wr_d  = WR_ARITH;
            end
            default: wr_d = '0;
        endcase

        rhs_eff_d = sub_d ? ~rhs_d : rhs_d;
        cin_eff_d = sub_d ? ~cin_d : cin_d;
        sum_d = {1'b0, lhs_d} + {1'b0, rhs_eff_d} + {{ALU_W{1'b0}}, cin_eff_d};
        low_d = {1'b0, lhs_d[HALF_W-1:0]} + {1'b0, rhs_eff_d[HALF_W-1:0]}
              + {{HALF_W{1'b0}}, cin_eff_d};

        n_d = sum_d[ALU_W-1];
        v_d = (lhs_d[ALU_W-1] == rhs_eff_d[ALU_W-1]) && (sum_d[ALU_W-1] != lhs_d[ALU_W-1]);
        z_d = (sum_d[ALU_W-1:0] == '0) && ((op_i != OP_SBC) || z_i);

        out_o.res        = sum_d[ALU_W-1:0];
        out_o.wr         = wr_d;
        out_o.val        = '0;
        out_o.val[FLG_C] = sum_d[ALU_W] ^ sub_d;
        out_o.val[FLG_Z] = z_d;
        out_o.val[FLG_N] = n_d;
        out_o.val[FLG_V] = v_d;
        out_o.val[FLG_S] = n_d ^ v_d;
        out_o.val[FLG_H] = low_d[HALF_W] ^ sub_d;
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e          op_i,
    input  logic [ALU_W-1:0] a_i,
    input  logic [ALU_W-1:0] b_i,
    input  logic             c_i,
    output unit_out_t        out_o
);

    logic [ALU_W-1:0] res_d;
    logic [ALU_W-1:0] wr_d;
    logic             c_d;
    logic             shift_d;
    logic             n_d;
    logic             v_d;

    always_comb begin
        res_d   = a_i;
        wr_d    = '0;
        c_d     = 1'b0;
        shift_d = 1'b0;
        case (op_i)
            OP_AND: begin
                res_d = a_i & b_i;
                wr_d  = WR_ZNVS;
            end
            OP_OR: begin
                res_d = a_i | b_i;
                wr_d  = WR_ZNVS;
            end
            OP_XOR: begin
                res_d = a_i ^ b_i;
                wr_d  = WR_ZNVS;
            end
            OP_COM: begin
                res_d = ~a_i;
                c_d   = 1'b1;
                wr_d  = WR_SHIFT;
            end
            OP_LSL: begin
                res_d   = {a_i[ALU_W-2:0], 1'b0};
                c_d     = a_i[ALU_W-1];
                shift_d = 1'b1;
                wr_d    = WR_SHIFT;
            end
            OP_LSR: begin
                res_d   = {1'b0, a_i[ALU_W-1:1]};
                c_d     = a_i[0];
                shift_d = 1'b1;
                wr_d    = WR_SHIFT;
            end
            OP_ASR: begin
                res_d   = {a_i[ALU_W-1], a_i[ALU_W-1:1]};
                c_d     = a_i[0];
                shift_d = 1'b1;
                wr_d    = WR_SHIFT;
            end
            OP_ROL: begin
                res_d   = {a_i[ALU_W-2:0], c_i};
                c_d     = a_i[ALU_W-1];
                shift_d = 1'b1;
                wr_d    = WR_SHIFT;
            end
            OP_ROR: begin
                res_d   = {c_i, a_i[ALU_W-1:1]};
                c_d     = a_i[0];
                shift_d = 1'b1;
                wr_d    = WR_SHIFT;
            end
            OP_SWAP: begin
                res_d = {a_i[HALF_W-1:0], a_i[ALU_W-1:HALF_W]};
                wr_d  = '0;
            end
            default: res_d = a_i;
        endcase

        n_d = res_d[ALU_W-1];
        v_d = shift_d & (n_d ^ c_d);

        out_o.res        = res_d;
        out_o.wr         = wr_d;
        out_o.val        = '0;
        out_o.val[FLG_C] = c_d;
        out_o.val[FLG_Z] = (res_d == '0);
        out_o.val[FLG_N] = n_d;
        out_o.val[FLG_V] = v_d;
        out_o.val[FLG_S] = n_d ^ v_d;
    end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic [ALU_W-1:0] a_i,
    input  logic [ALU_W-1:0] b_i,
    input  logic [IDX_W-1:0] bit_i,
    output logic [ALU_W-1:0] result_o,
    output logic [ALU_W-1:0] sreg_o
);

    alu_op_e          op_d;
    unit_out_t        arith_d;
    unit_out_t        logic_d;
    unit_out_t        sel_d;
    logic [ALU_W-1:0] merged_d;
    alu_state_t       st_d;
    alu_state_t       st_q;

    assign op_d = alu_op_e'(op_i);

    alu8_arith u_arith (
        .op_i (op_d),
        .a_i  (a_i),
        .b_i  (b_i),
        .c_i  (st_q.sreg[FLG_C]),
        .z_i  (st_q.sreg[FLG_Z]),
        .out_o(arith_d)
    );

    alu8_logic u_logic (
        .op_i (op_d),
        .a_i  (a_i),
        .b_i  (b_i),
        .c_i  (st_q.sreg[FLG_C]),
        .out_o(logic_d)
    );

    always_comb begin
        sel_d.res = a_i;
        sel_d.val = '0;
        sel_d.wr  = '0;
        case (op_d)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC, OP_NEG:
                sel_d = arith_d;
            OP_AND, OP_OR, OP_XOR, OP_COM, OP_LSL, OP_LSR, OP_ASR,
            OP_ROL, OP_ROR, OP_SWAP:
                sel_d = logic_d;
            OP_BSET: begin
                sel_d.wr  = ALU_W'(1) << bit_i;
                sel_d.val = '1;
            end
            OP_BCLR: begin
                sel_d.wr  = ALU_W'(1) << bit_i;
                sel_d.val = '0;
            end
            default: sel_d.wr = '0;
        endcase
    end

    for (genvar g = 0; g < ALU_W; g++) begin : g_merge
        assign merged_d[g] = sel_d.wr[g] ? sel_d.val[g] : st_q.sreg[g];
    end

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.sreg = merged_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = sel_d.res;
    assign sreg_o   = st_q.sreg;

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(st_q.sreg));

    assert_it_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i != OP_BSET && op_i != OP_BCLR)
        |=> st_q.sreg[FLG_I:FLG_T] == $past(st_q.sreg[FLG_I:FLG_T]));

    assert_logic_v_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR))
        |=> !st_q.sreg[FLG_V]);

    assert_swap_no_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_SWAP) |=> $stable(st_q.sreg));

    assert_bit_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_BSET) |=> st_q.sreg[$past(bit_i)]);

    assert_bit_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_BCLR) |=> !st_q.sreg[$past(bit_i)]);

    assert_sign_rule_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i <= OP_ROR)
        |=> st_q.sreg[FLG_S] == (st_q.sreg[FLG_N] ^ st_q.sreg[FLG_V]));

    assert_unused_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i > OP_BCLR) |=> $stable(st_q.sreg));

endmodule

// File: tb/test_alu8_flags.sv
`timescale 1ns/1ps
module test_alu8_flags;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic [2:0] bit_i = '0;
    logic [7:0] result_o;
    logic [7:0] sreg_o;

    int   n_checks = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    logic [7:0] ms = '0;

    always #10 clk = ~clk;

    alu8_flags i_alu8_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .bit_i   (bit_i),
        .result_o(result_o),
        .sreg_o  (sreg_o)
    );

    function automatic string req_of(int op);
        case (op)
            0, 1:          return "R3";
            2, 3:          return "R4";
            4, 5, 6:       return "R5";
            7, 8:          return "R7";
            9, 10:         return "R6";
            11, 12, 13:    return "R8";
            14, 15:        return "R9";
            16:            return "R10";
            17, 18:        return "R11";
            default:       return "R13";
        endcase
    endfunction

    function automatic int sx(int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // Returns {result, next status}
    function automatic logic [15:0] model(int op, int a, int b, int bi, logic [7:0] s);
        int r = a;
        int t;
        int sv;
        int c = s[0];
        logic [7:0] ns = s;
        bit upd_nv = 1'b0;
        case (op)
            0, 1, 2, 3: begin
                int cc = (op == 1 || op == 3) ? c : 0;
                if (op < 2) begin
                    t = a + b + cc;
                    ns[0] = (t > 255);
                    ns[5] = (((a % 16) + (b % 16) + cc) > 15);
                    sv = sx(a) + sx(b) + cc;
                end else begin
                    t = a - b - cc;
                    ns[0] = (t < 0);
                    ns[5] = (((a % 16) - (b % 16) - cc) < 0);
                    sv = sx(a) - sx(b) - cc;
                end
                r = (t + 512) % 256;
                ns[3] = (sv > 127 || sv < -128);
                ns[1] = (op == 3) ? (r == 0 && s[1]) : (r == 0);
                upd_nv = 1'b1;
            end
            4, 5, 6: begin
                r = (op == 4) ? (a & b) : (op == 5) ? (a | b) : (a ^ b);
                ns[3] = 1'b0;
                ns[1] = (r == 0);
                upd_nv = 1'b1;
            end
            7: begin
                r = 255 - a;
                ns[0] = 1'b1;
                ns[3] = 1'b0;
                ns[1] = (r == 0);
                upd_nv = 1'b1;
            end
            8: begin
                r = (256 - a) % 256;
                ns[0] = (a != 0);
                ns[5] = ((a % 16) != 0);
                ns[3] = (a == 128);
                ns[1] = (r == 0);
                upd_nv = 1'b1;
            end
            9, 10: begin
                r = (op == 9) ? (a + 1) % 256 : (a + 255) % 256;
                ns[3] = (op == 9) ? (a == 127) : (a == 128);
                ns[1] = (r == 0);
                upd_nv = 1'b1;
            end
            11, 12, 13, 14, 15: begin
                case (op)
                    11: begin r = (a * 2) % 256;             ns[0] = a / 128; end
                    12: begin r = a / 2;                     ns[0] = a % 2; end
                    13: begin r = a / 2 + (a / 128) * 128;   ns[0] = a % 2; end
                    14: begin r = (a * 2) % 256 + c;         ns[0] = a / 128; end
                    default: begin r = a / 2 + c * 128;      ns[0] = a % 2; end
                endcase
                ns[1] = (r == 0);
                ns[3] = (r / 128) ^ ns[0];
                upd_nv = 1'b1;
            end
            16: r = (a % 16) * 16 + a / 16;
            17: ns[bi] = 1'b1;
            18: ns[bi] = 1'b0;
            default: r = a;
        endcase
        if (upd_nv) begin
            ns[2] = (r / 128);
            ns[4] = ns[2] ^ ns[3];
        end
        return {r[7:0], ns};
    endfunction

    task automatic check8(string req, string what, logic [7:0] got, logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic run(int op, int a, int b, int bi, bit en);
        logic [15:0] m;
        logic [7:0]  exp;
        @(negedge clk);
        op_i  = op[4:0];
        a_i   = a[7:0];
        b_i   = b[7:0];
        bit_i = bi[2:0];
        en_i  = en;
        #1;
        m = model(op, a, b, bi, ms);
        check8(req_of(op), $sformatf("result op=%0d a=%02h b=%02h", op, a, b), result_o, m[15:8]);
        @(posedge clk);
        #1;
        exp = en ? m[7:0] : ms;
        check8(en ? req_of(op) : "R1", $sformatf("status op=%0d a=%02h b=%02h en=%0d", op, a, b, en),
               sreg_o, exp);
        if (en && op <= 15)
            check8("R12", "S vs N^V", {7'd0, sreg_o[4]}, {7'd0, sreg_o[2] ^ sreg_o[3]});
        ms = exp;
        en_i = 1'b0;
    endtask

    function automatic int bpick(int k);
        case (k)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
            4: return 8'h7F;  5: return 8'h80;  6: return 8'hFF;  7: return 8'hFE;
            default: return (k * 37 + 11) % 256;
        endcase
    endfunction

    initial begin
        #3_000_000;
        if (!finished) begin
            n_bad++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check8("R1", "status in reset", sreg_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check8("R1", "status after reset", sreg_o, 8'h00);

        // R2: I and T survive an add; 0xFF+0x01 gives H,Z,C set
        run(17, 0, 0, 7, 1'b1);
        run(17, 0, 0, 6, 1'b1);
        run(0, 8'hFF, 8'h01, 0, 1'b1);
        check8("R2", "bit order after add", sreg_o, 8'hE3);

        // Two-operand sweep: R3 R4 R5
        for (int op = 0; op <= 6; op++)
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 16; k++)
                    run(op, a, bpick(k), 0, 1'b1);

        // Single-operand sweep: R6 R7 R8 R9 R10
        for (int pass = 0; pass < 2; pass++)
            for (int op = 7; op <= 16; op++)
                for (int a = 0; a < 256; a++)
                    run(op, (a + pass * 85) % 256, 0, 0, 1'b1);

        // R11: every index, set then clear
        for (int i = 0; i < 8; i++) run(17, 8'h3C, 0, i, 1'b1);
        for (int i = 0; i < 8; i++) run(18, 8'hC3, 0, i, 1'b1);

        // R4: SBC zero result keeps Z set, keeps Z clear
        run(17, 0, 0, 1, 1'b1);
        run(18, 0, 0, 0, 1'b1);
        run(3, 5, 5, 0, 1'b1);
        check8("R4", "SBC sticky Z set", {7'd0, sreg_o[1]}, 8'h01);
        run(18, 0, 0, 1, 1'b1);
        run(3, 5, 5, 0, 1'b1);
        check8("R4", "SBC sticky Z clear", {7'd0, sreg_o[1]}, 8'h00);

        // R13: unused codes
        run(17, 0, 0, 3, 1'b1);
        for (int op = 19; op < 32; op++) run(op, 8'h5A, 8'hA5, 2, 1'b1);

        // R1: idle edges keep status
        for (int op = 0; op <= 18; op++) run(op, 8'h80, 8'h80, 5, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule